// File: doc/BRIEF.md
# Wake-up Line Edge Capture Unit

This block watches sixteen asynchronous wake-up inputs and records, for each one, that a chosen edge has happened. Each input is synchronised, then compared with its value one cycle earlier. A per-line edge-select bit decides whether a low-to-high or a high-to-low transition counts. A qualifying transition sets a sticky pending flag for that line. The flags stay set until software clears them, and one combined interrupt request reports whether any flag is set.

Software reaches the block over a small byte-wide register bus with four registers. Two hold the edge-select bits and two hold the pending flags; in each pair the upper lines come first. Writing a pending byte replaces it, so writing 0 clears a flag and writing 1 sets it, which gives a software interrupt. Two rules protect events that land on a register access. A hardware edge on the same cycle as a pending-byte write still sets its flag. An edge on the same cycle as any edge-select write is discarded.

Top module: `wake_edge_capture`

## Requirements
- R1: After reset, all four registers read 00h, `pend_o` is 0 and `irq_o` is 0.
- R2: With edge-select bit = 1 for a line, a low-to-high transition of its input sets its pending flag, and a high-to-low transition does not.
- R3: With edge-select bit = 0 for a line, a high-to-low transition of its input sets its pending flag, and a low-to-high transition does not.
- R4: A pending flag is never cleared by hardware. It falls only when software writes 0 to that bit of its pending byte.
- R5: Writing 1 to a bit of a pending byte sets that flag, even when no edge has occurred.
- R6: When a hardware edge and a software write of 0 reach the same pending flag in the same cycle, the flag ends up set.
- R7: An edge detected in the same cycle as a write to either edge-select byte sets no pending flag on any line, and that edge is lost.
- R8: The register addresses are 0 = edge-select lines 15..8, 1 = edge-select lines 7..0, 2 = pending lines 15..8 and 3 = pending lines 7..0. A read returns the stored byte on `bus_rdata` one cycle after it is issued, and `bus_rdata` keeps that value until the next read.
- R9: `irq_o` is 1 exactly when at least one bit of `pend_o` is 1.
- R10: An input transition, applied between two clock edges, shows up in `pend_o` right after the third rising clock edge that follows it, and not after the second.
- R11: A write changes only the addressed byte. Every other register byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wk_in | input | 16 | Asynchronous wake-up inputs, one per line |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pend_o | output | 16 | Pending flags, bit n for line n |
| irq_o | output | 1 | OR of all pending flags |

## Verification
The bench drives each edge type on lines whose select bit both accepts it and rejects it. A polarity inversion shows up as flags set on the wrong edge, or as flags missing on the right one. It places a pending-byte clear and an edge-select rewrite on exactly the cycle where a synchronised edge is seen. A design that lets the clear win loses the event, and one that ignores the write-time rule raises a flag that must stay low. It counts the clock edges between an input change and the flag, which catches a synchroniser one stage short or one stage long. It also reads back all four addresses after byte writes, which exposes a swapped high/low decode or a write that leaks into the neighbouring byte.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    // decoded register access
    typedef struct packed {
        logic             pol;
        logic             pend;
        logic [IDX_W-1:0] idx;   // byte index inside the line vector
    } wk_dec_t;

    // high byte first inside each pair: edge-select bytes, then pending bytes
    function automatic wk_dec_t wk_decode(input logic [7:0] addr, input int nb);
        wk_dec_t d;
        int      a;
        d = '0;
        a = int'(addr);
        if (a < nb) begin
            d.pol = 1'b1;
            d.idx = IDX_W'(nb - 1 - a);
        end else if (a < 2 * nb) begin
            d.pend = 1'b1;
            d.idx  = IDX_W'(2 * nb - 1 - a);
        end
        return d;
    endfunction

endpackage

// File: rtl/wk_edge.sv
module wk_edge #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] trig_o
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic s1, s2, s3;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= line_i[g];
                s2 <= s1;
                s3 <= s2;
            end
        end

        // s2 is the synchronised level, s3 its value one cycle earlier
        assign trig_o[g] = pol_i[g] ? (s2 & ~s3) : (~s2 & s3);
    end

endmodule

// File: rtl/wk_regbank.sv
module wk_regbank
    import wk_pkg::*;
#(
    parameter int N  = 16,
    parameter int NB = N / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wk_dec_t           dec,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [N-1:0]      trig,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      pend_o
);

    logic         pol_wr;
    logic         pend_wr;
    logic [N-1:0] hw_set;

    always_comb begin
        pol_wr  = wr_en & dec.pol;
        pend_wr = wr_en & dec.pend;
        // an edge-select write discards every edge seen in that cycle
        hw_set  = pol_wr ? '0 : trig;
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                pol_o[b*BYTE_W +: BYTE_W]  <= '0;
                pend_o[b*BYTE_W +: BYTE_W] <= '0;
            end else begin
                if (pol_wr && dec.idx == IDX_W'(b))
                    pol_o[b*BYTE_W +: BYTE_W] <= wdata;
                if (pend_wr && dec.idx == IDX_W'(b))
                    pend_o[b*BYTE_W +: BYTE_W] <= wdata | hw_set[b*BYTE_W +: BYTE_W];
                else
                    pend_o[b*BYTE_W +: BYTE_W] <= pend_o[b*BYTE_W +: BYTE_W]
                                                | hw_set[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // R4
    no_hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_o) & ~pend_o) != '0) |-> $past(pend_wr));

    // R6
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((pend_o & $past(hw_set)) == $past(hw_set)));

    // R7
    pol_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        pol_wr |=> ((pend_o & ~$past(pend_o)) == '0));

endmodule

// File: rtl/wk_rdport.sv
module wk_rdport
    import wk_pkg::*;
#(
    parameter int N  = 16,
    parameter int NB = N / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  wk_dec_t           dec,
    input  logic [N-1:0]      pol,
    input  logic [N-1:0]      pend,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < NB; b++) begin
            if (dec.idx == IDX_W'(b)) begin
                if (dec.pend)
                    rd_byte = pend[b*BYTE_W +: BYTE_W];
                else if (dec.pol)
                    rd_byte = pol[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_byte;
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rdata));

endmodule

// File: rtl/wake_edge_capture.sv
module wake_edge_capture
    import wk_pkg::*;
#(
    parameter int N  = 16,
    localparam int NB = N / BYTE_W,
    localparam int AW = $clog2(2 * NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      wk_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [N-1:0]      pend_o,
    output logic              irq_o
);

    wk_dec_t      dec;
    logic         wr_en;
    logic         rd_en;
    logic [N-1:0] pol;
    logic [N-1:0] trig;

    always_comb begin
        dec   = wk_decode(8'(bus_addr), NB);
        wr_en = bus_sel & bus_we;
        rd_en = bus_sel & ~bus_we;
    end

    wk_edge #(.N(N)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (wk_in),
        .pol_i  (pol),
        .trig_o (trig)
    );

    wk_regbank #(.N(N), .NB(NB)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .dec    (dec),
        .wdata  (bus_wdata),
        .trig   (trig),
        .pol_o  (pol),
        .pend_o (pend_o)
    );

    wk_rdport #(.N(N), .NB(NB)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .dec   (dec),
        .pol   (pol),
        .pend  (pend_o),
        .rdata (bus_rdata)
    );

    assign irq_o = |pend_o;

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> (pend_o == '0 && bus_rdata == '0));

endmodule

// File: tb/test_wake_edge_capture.sv
`timescale 1ns/1ps
module test_wake_edge_capture;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wk_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pend_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // R8 address map used by the bench
    localparam logic [1:0] A_POL_HI  = 2'd0;
    localparam logic [1:0] A_POL_LO  = 2'd1;
    localparam logic [1:0] A_PEND_HI = 2'd2;
    localparam logic [1:0] A_PEND_LO = 2'd3;

    always #10 clk = ~clk;

    wake_edge_capture i_wake_edge_capture (
        .clk(clk), .rst(rst), .wk_in(wk_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard for reads
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_sel && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected read", 32'd1, 32'd0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(bus_rdata), 32'(e));
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        wk_in[i] = v;
    endtask

    // change a line, wait three edges, check the flags
    task automatic edge_and_check(input int i, input logic v, input logic [15:0] e, input string t);
        set_line(i, v);
        repeat (3) @(negedge clk);
        chk(t, 32'(pend_o), 32'(e));
    endtask

    // change a line and issue a write on the cycle its edge is detected
    task automatic edge_with_write(input int i, input logic v, input logic [1:0] a, input logic [7:0] d);
        set_line(i, v);
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pend after reset", 32'(pend_o), 32'h0);
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(A_POL_HI, 8'h00, "R1 pol hi reset");
        rd(A_POL_LO, 8'h00, "R1 pol lo reset");
        rd(A_PEND_HI, 8'h00, "R1 pend hi reset");
        rd(A_PEND_LO, 8'h00, "R1 pend lo reset");

        wr(A_POL_HI, 8'h80);
        wr(A_POL_LO, 8'h01);
        rd(A_POL_HI, 8'h80, "R11 pol hi readback");
        rd(A_POL_LO, 8'h01, "R11 pol lo readback");

        // R10 latency and R2 rising edge
        set_line(0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 not yet after two edges", 32'(pend_o), 32'h0);
        @(negedge clk);
        chk("R2 rising sets line0", 32'(pend_o), 32'h0001);
        chk("R9 irq high", 32'(irq_o), 32'h1);

        edge_and_check(1, 1'b1, 16'h0001, "R3 rising ignored on falling line1");
        edge_and_check(1, 1'b0, 16'h0003, "R3 falling sets line1");
        edge_and_check(0, 1'b0, 16'h0003, "R2 falling ignored on rising line0, R4 sticky");
        rd(A_PEND_LO, 8'h03, "R8 pend lo read");
        rd(A_PEND_HI, 8'h00, "R8 pend hi read");

        wr(A_PEND_LO, 8'h00);
        chk("R4 software clear", 32'(pend_o), 32'h0);
        chk("R9 irq low", 32'(irq_o), 32'h0);

        wr(A_PEND_HI, 8'h40);
        chk("R5 software set", 32'(pend_o), 32'h4000);
        chk("R5 irq from software set", 32'(irq_o), 32'h1);
        rd(A_PEND_HI, 8'h40, "R5 pend hi read");
        wr(A_PEND_HI, 8'h00);

        // R6: clear of the same byte on the detect cycle
        wr(A_PEND_HI, 8'h01);
        chk("R5 line8 set", 32'(pend_o), 32'h0100);
        edge_with_write(15, 1'b1, A_PEND_HI, 8'h00);
        chk("R6 hw set beats clear", 32'(pend_o), 32'h8000);
        wr(A_PEND_HI, 8'h00);

        // R7: edge-select write on the detect cycle
        edge_with_write(0, 1'b1, A_POL_HI, 8'h80);
        chk("R7 edge dropped", 32'(pend_o), 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 edge stays lost", 32'(pend_o), 32'h0);
        set_line(0, 1'b0);
        repeat (3) @(negedge clk);
        edge_and_check(0, 1'b1, 16'h0001, "R7 later edge still captured");
        wr(A_PEND_LO, 8'h00);

        wr(A_PEND_LO, 8'hFF);
        chk("R11 low byte write only", 32'(pend_o), 32'h00FF);
        rd(A_PEND_HI, 8'h00, "R11 pend hi untouched");
        rd(A_POL_LO, 8'h01, "R11 pol lo untouched");
        repeat (3) @(negedge clk);
        chk("R8 rdata holds", 32'(bus_rdata), 32'h01);
        chk("R8 reads drained", 32'(exp_q.size()), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule